// File: doc/BRIEF.md
# Daisy-Chain Bus Requester

This block sits between one local bus master and a backplane whose bus grant travels serially from board to board. When the local master wants the bus, the block raises a request on the one backplane request level it is configured for. When the grant reaches it, the block either keeps the grant for its own master or hands it on to the next board down the chain. It keeps the grant if its master has a request pending, and forwards it otherwise.

The grant input and the local want signal both arrive without any timing relation to the local clock. Each one passes through its own multi-stage synchronizer. The keep-or-forward choice is made in one registered state machine, and only from the settled views of both signals. The choice is then held until the grant goes away. A grant edge and a want edge that land together therefore resolve to exactly one outcome, and the bus can never be kept and forwarded at the same moment.

While the block owns the bus, it asserts bus busy and withdraws its request. It holds busy until the local master reports completion. The forwarded grant is gated by the raw incoming grant, so it falls as soon as the upstream grant falls.

Top module: `chain_bus_requester`

## Requirements
- R1: While reset is asserted and after it is released with all inputs low, bus_req, grant_out and bus_busy are all zero.
- R2: With mst_want held high and no grant present, bit LEVEL of bus_req is set SYNC_STAGES clock edges after mst_want rises. No other bit of bus_req is ever set.
- R3: If the synchronized grant arrives while the synchronized want is high, bus_busy is set SYNC_STAGES+1 edges after grant_in rises. In the same cycle bus_req returns to zero, and grant_out stays low.
- R4: If the synchronized grant arrives while the synchronized want is low, grant_out rises SYNC_STAGES+1 edges after grant_in rises, and bus_busy stays low.
- R5: grant_out and bus_busy are never high in the same cycle.
- R6: Once the grant has been forwarded, a later rise of mst_want does not convert it into ownership: grant_out stays high until grant_in falls. Once the bus is owned, removing grant_in leaves bus_busy high and grant_out low.
- R7: grant_out is low in any cycle in which grant_in is low, with no clock edge needed.
- R8: bus_busy stays high until a clock edge at which mst_done is high, and falls at that edge. If grant_in is still high afterwards, grant_out stays low until grant_in has been removed.
- R9: When mst_want and grant_in rise in the same cycle, the grant is kept: bus_busy rises and grant_out stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_want | input | 1 | Local master wants the bus (asynchronous) |
| mst_done | input | 1 | Local master finished its tenure (synchronous, one-cycle pulse) |
| grant_in | input | 1 | Grant from the upstream neighbour in the chain (asynchronous) |
| bus_req | output | NUM_LEVELS | Backplane request lines; only bit LEVEL is ever driven high |
| grant_out | output | 1 | Grant forwarded to the downstream neighbour |
| bus_busy | output | 1 | Local master owns the bus |

## Verification
Some properties are checked by assertions on every cycle:
- grant_out and bus_busy are never high together;
- request bits appear only on the configured level, and are withdrawn while busy;
- the forwarded grant is gated by the raw grant;
- busy is held until completion and released on it;
- a forwarded grant is held steady.

Other behaviour can only be shown by the bench's scenarios: the exact keep-or-forward outcome for each skew between the want and grant edges, the synchronizer latency, and the refusal to forward a grant that is still present after ownership ends. The bench sweeps that skew from want three cycles early to want three cycles late, which includes simultaneous edges.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

   // Requester state: waiting, forwarding, owning, or draining a stale grant.
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PASS  = 2'd1,
      ST_OWN   = 2'd2,
      ST_DRAIN = 2'd3
   } req_state_t;

endpackage

// File: rtl/cbr_sync.sv
module cbr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cbr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_async};
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cbr_decider.sv
module cbr_decider
   import cbr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic gnt_s,
   input  logic want_s,
   input  logic done,
   output logic pass_o,
   output logic own_o,
   output logic req_o
);

   req_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: begin
            if (gnt_s) begin
               st_d = want_s ? ST_OWN : ST_PASS;
            end
         end
         ST_PASS: begin
            if (!gnt_s) begin
               st_d = ST_IDLE;
            end
         end
         ST_OWN: begin
            if (done) begin
               st_d = gnt_s ? ST_DRAIN : ST_IDLE;
            end
         end
         ST_DRAIN: begin
            if (!gnt_s) begin
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   assign pass_o = (st_q == ST_PASS);
   assign own_o  = (st_q == ST_OWN);
   assign req_o  = want_s && ((st_q == ST_IDLE) || (st_q == ST_PASS));

endmodule

// File: rtl/cbr_level_drive.sv
module cbr_level_drive #(
   parameter int NUM_LEVELS = 4,
   parameter int LEVEL      = 0
) (
   input  logic                  req,
   output logic [NUM_LEVELS-1:0] lines
);

   generate
      if (LEVEL < 0 || LEVEL >= NUM_LEVELS) begin : g_bad_level
         $error("cbr_level_drive: LEVEL out of range");
      end
      for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_line
         if (lv == LEVEL) begin : g_on
            assign lines[lv] = req;
         end else begin : g_off
            assign lines[lv] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/chain_bus_requester.sv
module chain_bus_requester #(
   parameter int SYNC_STAGES = 2,
   parameter int NUM_LEVELS  = 4,
   parameter int LEVEL       = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mst_want,
   input  logic                  mst_done,
   input  logic                  grant_in,
   output logic [NUM_LEVELS-1:0] bus_req,
   output logic                  grant_out,
   output logic                  bus_busy
);

   generate
      if (NUM_LEVELS < 1) begin : g_bad_levels
         $error("chain_bus_requester: NUM_LEVELS must be positive");
      end
   endgenerate

   logic gnt_s;
   logic want_s;
   logic pass_st;
   logic own_st;
   logic req_act;

   cbr_sync #(.STAGES(SYNC_STAGES)) u_sync_gnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (grant_in),
      .q_sync  (gnt_s)
   );

   cbr_sync #(.STAGES(SYNC_STAGES)) u_sync_want (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (mst_want),
      .q_sync  (want_s)
   );

   cbr_decider u_decide (
      .clk    (clk),
      .rst_n  (rst_n),
      .gnt_s  (gnt_s),
      .want_s (want_s),
      .done   (mst_done),
      .pass_o (pass_st),
      .own_o  (own_st),
      .req_o  (req_act)
   );

   cbr_level_drive #(.NUM_LEVELS(NUM_LEVELS), .LEVEL(LEVEL)) u_lvl (
      .req   (req_act),
      .lines (bus_req)
   );

   // Forwarding is decided from synchronized state but released by the raw grant.
   assign grant_out = pass_st & grant_in;
   assign bus_busy  = own_st;

endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
   parameter int NUM_LEVELS = 4,
   parameter int LEVEL      = 0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  grant_in,
   input logic                  mst_done,
   input logic [NUM_LEVELS-1:0] bus_req,
   input logic                  grant_out,
   input logic                  bus_busy
);

   localparam logic [NUM_LEVELS-1:0] LVL_MASK =
      {{(NUM_LEVELS-1){1'b0}}, 1'b1} << LEVEL;

   assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_out && bus_busy));

   assert_level_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req & ~LVL_MASK) == '0);

   assert_no_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy |-> (bus_req == '0));

   assert_follow_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_in |-> !grant_out);

   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_busy && !mst_done) |=> bus_busy);

   assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_busy && mst_done) |=> !bus_busy);

   assert_pass_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_out && grant_in) |=> (grant_out || !grant_in));

endmodule

bind chain_bus_requester cbr_checker #(
   .NUM_LEVELS (NUM_LEVELS),
   .LEVEL      (LEVEL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grant_in  (grant_in),
   .mst_done  (mst_done),
   .bus_req   (bus_req),
   .grant_out (grant_out),
   .bus_busy  (bus_busy)
);

// File: tb/sim_chain_bus_requester.sv
`timescale 1ns/1ps
module sim_chain_bus_requester;

   localparam int SYNC   = 2;
   localparam int NLVL   = 4;
   localparam int LVL    = 2;
   localparam logic [NLVL-1:0] MASK = 4'b0100;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            mst_want = 1'b0;
   logic            mst_done = 1'b0;
   logic            grant_in = 1'b0;
   logic [NLVL-1:0] bus_req;
   logic            grant_out;
   logic            bus_busy;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   chain_bus_requester #(.SYNC_STAGES(SYNC), .NUM_LEVELS(NLVL), .LEVEL(LVL)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mst_want  (mst_want),
      .mst_done  (mst_done),
      .grant_in  (grant_in),
      .bus_req   (bus_req),
      .grant_out (grant_out),
      .bus_busy  (bus_busy)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_tenure();
      mst_done = 1'b1;
      mst_want = 1'b0;
      step(1);
      mst_done = 1'b0;
      chk("R8 busy falls on done", {31'b0, bus_busy}, 0);
      chk("R8 no forward after done", {31'b0, grant_out}, 0);
      chk("R8 request idle", {28'b0, bus_req}, 0);
      step(3);
      chk("R8 stale grant not forwarded", {31'b0, grant_out}, 0);
      grant_in = 1'b0;
      step(4);
      chk("R1 quiet after cleanup", {29'b0, bus_req != 0, grant_out, bus_busy}, 0);
   endtask

   task automatic run_offset(int d);
      bit take = (d <= 0);
      if (d < 0) begin
         mst_want = 1'b1;
         if (d == -3) begin
            step(SYNC);
            chk("R2 request on level", {28'b0, bus_req}, {28'b0, MASK});
            step(1);
         end else begin
            step(-d);
         end
      end else if (d == 0) begin
         mst_want = 1'b1;
      end
      grant_in = 1'b1;
      if (d > 0) begin
         step(d);
         mst_want = 1'b1;
      end
      step(4);
      chk("R5 exclusive", {31'b0, grant_out & bus_busy}, 0);
      if (take) begin
         chk(d == 0 ? "R9 coincident takes" : "R3 take busy", {31'b0, bus_busy}, 1);
         chk("R3 take no forward", {31'b0, grant_out}, 0);
         chk("R3 request withdrawn", {28'b0, bus_req}, 0);
         step(3);
         chk("R8 busy held", {31'b0, bus_busy}, 1);
         grant_in = 1'b0;
         step(4);
         chk("R6 owned ignores grant drop", {30'b0, bus_busy, grant_out}, 32'h2);
         grant_in = 1'b1;
         step(4);
         chk("R6 owned ignores grant return", {30'b0, bus_busy, grant_out}, 32'h2);
      end else begin
         chk("R4 forwarded", {31'b0, grant_out}, 1);
         chk("R6 late want keeps pass", {31'b0, bus_busy}, 0);
         chk("R2 request while passing", {28'b0, bus_req}, {28'b0, MASK});
         grant_in = 1'b0;
         #1;
         chk("R7 forward drops at once", {31'b0, grant_out}, 0);
         step(4);
         chk("R2 request in idle", {28'b0, bus_req}, {28'b0, MASK});
         grant_in = 1'b1;
         step(SYNC);
         chk("R3 latency not yet busy", {31'b0, bus_busy}, 0);
         step(1);
         chk("R3 take after re-grant", {31'b0, bus_busy}, 1);
         chk("R5 exclusive", {31'b0, grant_out & bus_busy}, 0);
      end
      finish_tenure();
   endtask

   initial begin
      step(1);
      chk("R1 reset outputs", {29'b0, bus_req != 0, grant_out, bus_busy}, 0);
      step(2);
      rst_n = 1'b1;
      step(2);
      chk("R1 after release", {29'b0, bus_req != 0, grant_out, bus_busy}, 0);
      // Pass latency with no want.
      grant_in = 1'b1;
      step(SYNC);
      chk("R4 latency not yet forwarded", {31'b0, grant_out}, 0);
      step(1);
      chk("R4 pass no want", {31'b0, grant_out}, 1);
      chk("R4 not busy", {31'b0, bus_busy}, 0);
      grant_in = 1'b0;
      #1;
      chk("R7 release", {31'b0, grant_out}, 0);
      step(4);
      for (int d = -3; d <= 3; d++) begin
         run_offset(d);
      end
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule